// File: doc/BRIEF.md
# Packet Timing Counter Controller

This block keeps the sample clock of one received OFDM packet. A coarse packet-detect pulse, seen while the block is idle, opens a packet and starts a 16-bit sample index at zero. The index then advances once for every accepted sample. When the long-correlation magnitude first rises strictly above a programmed threshold, the index is overwritten with a programmed timing value, and a fine-sync pulse marks the event. The index then continues counting from that value.

Independently of the index, a programmed 7-bit delay, captured at detection, decides when a one-sample start-of-processing pulse is raised. The delay is set so that processing begins on the fourth short training symbol of the preamble. An end-of-packet input closes the packet, freezes the index and cancels a pending start.

A soft reset bit in a control word clears all timing and detection state. Configuration values arrive as plain inputs and are never changed by the block. Every state change except reset waits for the sample-valid strobe.

Top module: `ptc_timing_top`

## Requirements
- R1: After the synchronous reset `rst`, `samp_idx` is 0 and `pkt_active`, `fine_sync` and `proc_start` are 0.
- R2: While idle, a sample with `coarse_det` high opens a packet. After that clock edge `pkt_active` is 1 and `samp_idx` is 0, and each later accepted sample adds 1.
- R3: A long-correlation crossing requires `corr_mag > cfg_corr_thresh`; equality is not a crossing. A crossing loads `samp_idx` with `cfg_load_idx` and raises `fine_sync` for one sample period.
- R4: Only the first crossing of a packet reloads the index. Later crossings within the same packet leave the count running and raise no `fine_sync`.
- R5: `samp_idx` saturates at 16'hFFFF and never wraps.
- R6: A `coarse_det` that arrives while a packet is open has no effect, and the index keeps advancing by one.
- R7: With delay D captured at detection, `proc_start` rises on the (D+1)-th accepted sample after detection and stays high for exactly one sample period. D=0 fires it on the first sample after detection.
- R8: An accepted sample with `end_pkt` high clears `pkt_active`, freezes `samp_idx` and cancels a pending `proc_start`. It takes priority over a crossing in the same sample.
- R9: On cycles with `smp_valid` low, `samp_idx`, `pkt_active` and the pulses keep their values, whatever the other inputs do.
- R10: Bit 0 of `ctrl_word` set to 1 acts as a soft reset with the effect of R1, on any cycle. The other bits of `ctrl_word` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Control word; bit 0 is the soft reset |
| smp_valid | input | 1 | Sample-valid strobe |
| coarse_det | input | 1 | Coarse packet-detect event |
| end_pkt | input | 1 | End-of-packet event |
| corr_mag | input | 16 | Long-correlation magnitude, unsigned |
| cfg_corr_thresh | input | 16 | Correlation threshold, unsigned |
| cfg_load_idx | input | 16 | Index value loaded on the first crossing |
| cfg_start_dly | input | 7 | Detect-to-processing delay in samples |
| samp_idx | output | 16 | Running sample index |
| pkt_active | output | 1 | Packet open |
| fine_sync | output | 1 | Fine-sync pulse on the first crossing |
| proc_start | output | 1 | Start-of-processing pulse |

## Verification
A vector table runs whole packets across four patterns. The first is an early crossing at delay 0. The second has a magnitude exactly equal to the threshold, which shows the strict comparison. The third is a sustained crossing far above a mid-range threshold, which separates the first crossing from repeated ones. The fourth uses the maximum delay with no crossing, which exposes off-by-one errors in the delay countdown and shows a free-running index. Directed tests then hold the valid strobe low while every other input is active, issue a coarse detect inside a packet, load an index near the top to reach saturation, and close a packet while a start is still pending and while a crossing is present. They also toggle the soft-reset bit against the other control bits.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic {
    PKT_IDLE   = 1'b0,
    PKT_TIMING = 1'b1
  } pkt_state_e;
endpackage

// File: rtl/ptc_pkt_fsm.sv
module ptc_pkt_fsm
  import ptc_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic smp_valid,
  input  logic coarse_det,
  input  logic end_pkt,
  input  logic cross_hit,
  output logic active,
  output logic open_evt,
  output logic close_evt,
  output logic first_cross,
  output logic run_evt
);
  pkt_state_e state_q;
  logic       synced_q;

  assign active      = (state_q == PKT_TIMING);
  assign open_evt    = !active && smp_valid && coarse_det;
  assign close_evt   = active && smp_valid && end_pkt;
  assign run_evt     = active && smp_valid && !end_pkt;
  assign first_cross = run_evt && cross_hit && !synced_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q  <= PKT_IDLE;
      synced_q <= 1'b0;
    end else if (open_evt) begin
      state_q  <= PKT_TIMING;
      synced_q <= 1'b0;
    end else if (close_evt) begin
      state_q  <= PKT_IDLE;
    end else if (first_cross) begin
      synced_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ptc_sample_counter.sv
module ptc_sample_counter #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             start,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      idx_q <= '0;
    end else if (start) begin
      idx_q <= '0;
    end else if (load) begin
      idx_q <= load_val;
    end else if (step && (idx_q != IDX_MAX)) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx = idx_q;
endmodule

// File: rtl/ptc_start_delay.sv
module ptc_start_delay #(
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             smp_valid,
  input  logic             start,
  input  logic             cancel,
  input  logic             advance,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             pulse
);
  logic [DLY_W-1:0] cnt_q;
  logic             armed_q;
  logic             pulse_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else if (smp_valid) begin
      pulse_q <= 1'b0;
      if (start) begin
        cnt_q   <= dly_cfg;
        armed_q <= 1'b1;
      end else if (cancel) begin
        armed_q <= 1'b0;
      end else if (advance && armed_q) begin
        if (cnt_q == '0) begin
          pulse_q <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/ptc_timing_top.sv
module ptc_timing_top #(
  parameter int IDX_W   = 16,
  parameter int THR_W   = 16,
  parameter int DLY_W   = 7,
  parameter int CTL_W   = 32,
  parameter int RST_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] ctrl_word,
  input  logic             smp_valid,
  input  logic             coarse_det,
  input  logic             end_pkt,
  input  logic [THR_W-1:0] corr_mag,
  input  logic [THR_W-1:0] cfg_corr_thresh,
  input  logic [IDX_W-1:0] cfg_load_idx,
  input  logic [DLY_W-1:0] cfg_start_dly,
  output logic [IDX_W-1:0] samp_idx,
  output logic             pkt_active,
  output logic             fine_sync,
  output logic             proc_start
);
  logic clr;
  logic cross_hit;
  logic open_evt, close_evt, first_cross, run_evt;
  logic fsync_q;

  assign clr       = rst || ctrl_word[RST_BIT];
  assign cross_hit = (corr_mag > cfg_corr_thresh);

  ptc_pkt_fsm u_fsm (
    .clk        (clk),
    .clr        (clr),
    .smp_valid  (smp_valid),
    .coarse_det (coarse_det),
    .end_pkt    (end_pkt),
    .cross_hit  (cross_hit),
    .active     (pkt_active),
    .open_evt   (open_evt),
    .close_evt  (close_evt),
    .first_cross(first_cross),
    .run_evt    (run_evt)
  );

  ptc_sample_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk     (clk),
    .clr     (clr),
    .start   (open_evt),
    .load    (first_cross),
    .load_val(cfg_load_idx),
    .step    (run_evt),
    .idx     (samp_idx)
  );

  ptc_start_delay #(.DLY_W(DLY_W)) u_dly (
    .clk      (clk),
    .clr      (clr),
    .smp_valid(smp_valid),
    .start    (open_evt),
    .cancel   (close_evt),
    .advance  (run_evt),
    .dly_cfg  (cfg_start_dly),
    .pulse    (proc_start)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      fsync_q <= 1'b0;
    end else if (smp_valid) begin
      fsync_q <= first_cross;
    end
  end

  assign fine_sync = fsync_q;
endmodule

// File: rtl/ptc_timing_chk.sv
module ptc_timing_chk #(
  parameter int IDX_W   = 16,
  parameter int THR_W   = 16,
  parameter int DLY_W   = 7,
  parameter int CTL_W   = 32,
  parameter int RST_BIT = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [CTL_W-1:0] ctrl_word,
  input logic             smp_valid,
  input logic             coarse_det,
  input logic             end_pkt,
  input logic [THR_W-1:0] corr_mag,
  input logic [THR_W-1:0] cfg_corr_thresh,
  input logic [IDX_W-1:0] cfg_load_idx,
  input logic [IDX_W-1:0] samp_idx,
  input logic             pkt_active,
  input logic             fine_sync,
  input logic             proc_start
);
  localparam logic [IDX_W-1:0] MAXV = {IDX_W{1'b1}};

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[RST_BIT] |=> (samp_idx == '0) && !pkt_active && !fine_sync && !proc_start);

  assert_load_on_sync_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fine_sync) |-> (samp_idx == $past(cfg_load_idx)));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_active && smp_valid && (samp_idx == MAXV) && !(corr_mag > cfg_corr_thresh)
     && !ctrl_word[RST_BIT]) |=> (samp_idx == MAXV));

  assert_coarse_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_active && smp_valid && coarse_det && !end_pkt && !ctrl_word[RST_BIT]
     && !(corr_mag > cfg_corr_thresh) && (samp_idx != MAXV))
    |=> pkt_active && (samp_idx == IDX_W'($past(samp_idx) + 1'b1)));

  assert_start_in_packet_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(proc_start) |-> $past(smp_valid) && pkt_active);

  assert_valid_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !ctrl_word[RST_BIT]) |=>
      $stable(samp_idx) && $stable(pkt_active) && $stable(proc_start) && $stable(fine_sync));
endmodule

bind ptc_timing_top ptc_timing_chk #(
  .IDX_W(IDX_W), .THR_W(THR_W), .DLY_W(DLY_W), .CTL_W(CTL_W), .RST_BIT(RST_BIT)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ctrl_word      (ctrl_word),
  .smp_valid      (smp_valid),
  .coarse_det     (coarse_det),
  .end_pkt        (end_pkt),
  .corr_mag       (corr_mag),
  .cfg_corr_thresh(cfg_corr_thresh),
  .cfg_load_idx   (cfg_load_idx),
  .samp_idx       (samp_idx),
  .pkt_active     (pkt_active),
  .fine_sync      (fine_sync),
  .proc_start     (proc_start)
);

// File: tb/tb_ptc_timing_top.sv
module tb_ptc_timing_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] ctrl_word;
  logic        smp_valid, coarse_det, end_pkt;
  logic [15:0] corr_mag, cfg_corr_thresh, cfg_load_idx;
  logic [6:0]  cfg_start_dly;
  logic [15:0] samp_idx;
  logic        pkt_active, fine_sync, proc_start;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ptc_timing_top dut (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .smp_valid(smp_valid),
    .coarse_det(coarse_det), .end_pkt(end_pkt), .corr_mag(corr_mag),
    .cfg_corr_thresh(cfg_corr_thresh), .cfg_load_idx(cfg_load_idx),
    .cfg_start_dly(cfg_start_dly), .samp_idx(samp_idx), .pkt_active(pkt_active),
    .fine_sync(fine_sync), .proc_start(proc_start)
  );

  typedef struct packed {
    logic [6:0]  dly;
    logic [15:0] thr;
    logic [15:0] load;
    logic [7:0]  cross_at;
    logic [15:0] corr;
    logic [7:0]  nsamp;
    logic [7:0]  exp_start;
    logic [15:0] exp_idx;
    logic [7:0]  exp_fs;
  } vec_t;

  // corr is held at its value from sample cross_at onward (sustained crossing)
  localparam vec_t VEC [4] = '{
    '{7'd0,   16'd100,    16'd500,  8'd5,   16'd101,    8'd10,  8'd1,   16'd505,  8'd1},
    '{7'd3,   16'd100,    16'd500,  8'd5,   16'd100,    8'd10,  8'd4,   16'd10,   8'd0},
    '{7'd10,  16'h8000,   16'h0040, 8'd2,   16'hFFFF,   8'd20,  8'd11,  16'h0052, 8'd1},
    '{7'd127, 16'd50,     16'd7,    8'd200, 16'd0,      8'd130, 8'd128, 16'd130,  8'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic cd, input logic [15:0] cm, input logic ep);
    smp_valid = v; coarse_det = cd; corr_mag = cm; end_pkt = ep;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0; coarse_det = 1'b0; end_pkt = 1'b0; corr_mag = '0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen_at, nstart, nfs;
    rst = 1'b1; ctrl_word = '0; smp_valid = 0; coarse_det = 0; end_pkt = 0;
    corr_mag = '0; cfg_corr_thresh = '0; cfg_load_idx = '0; cfg_start_dly = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(samp_idx == 0, "R1 idx", samp_idx, 0);
    chk(!pkt_active && !fine_sync && !proc_start, "R1 flags",
        {pkt_active, fine_sync, proc_start}, 0);

    for (int i = 0; i < 4; i++) begin
      cfg_start_dly = VEC[i].dly; cfg_corr_thresh = VEC[i].thr; cfg_load_idx = VEC[i].load;
      step(1, 1, 16'd0, 0);
      chk(pkt_active && samp_idx == 0, "R2 open", samp_idx, 0);
      seen_at = 0; nstart = 0; nfs = 0;
      for (int s = 1; s <= int'(VEC[i].nsamp); s++) begin
        step(1, 0, (s >= int'(VEC[i].cross_at)) ? VEC[i].corr : 16'd0, 0);
        if (proc_start) begin nstart++; if (seen_at == 0) seen_at = s; end
        if (fine_sync) nfs++;
      end
      chk(seen_at == int'(VEC[i].exp_start), "R7 start sample", seen_at, VEC[i].exp_start);
      chk(nstart == 1, "R7 pulse width", nstart, 1);
      chk(samp_idx == VEC[i].exp_idx, "R3/R4 idx", samp_idx, VEC[i].exp_idx);
      chk(nfs == int'(VEC[i].exp_fs), "R4 fine sync count", nfs, VEC[i].exp_fs);
      step(1, 0, 16'd0, 1);
      chk(!pkt_active, "R8 closed", pkt_active, 0);
    end

    // R5 saturation
    cfg_start_dly = 0; cfg_corr_thresh = 16'd10; cfg_load_idx = 16'hFFFD;
    step(1, 1, 0, 0);
    step(1, 0, 16'd11, 0);
    chk(samp_idx == 16'hFFFD, "R3 load", samp_idx, 16'hFFFD);
    repeat (4) step(1, 0, 0, 0);
    chk(samp_idx == 16'hFFFF, "R5 saturate", samp_idx, 16'hFFFF);
    step(1, 0, 0, 1);

    // R8 end beats crossing in the same sample
    cfg_load_idx = 16'h0300;
    step(1, 1, 0, 0);
    step(1, 0, 16'd20, 1);
    chk(samp_idx == 0 && !pkt_active, "R8 priority idx", samp_idx, 0);
    chk(!fine_sync, "R8 priority sync", fine_sync, 0);

    // R9 valid gating, R6 coarse ignored
    cfg_start_dly = 7'd100;
    step(1, 1, 0, 0);
    repeat (3) step(1, 0, 0, 0);
    repeat (5) step(0, 1, 16'hFFFF, 1);
    chk(samp_idx == 3 && pkt_active, "R9 hold idx", samp_idx, 3);
    chk(!fine_sync, "R9 no sync", fine_sync, 0);
    step(1, 0, 0, 0);
    chk(samp_idx == 4, "R9 resume", samp_idx, 4);
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    chk(samp_idx == 6 && pkt_active, "R6 coarse ignored", samp_idx, 6);

    // R10 soft reset bit and other bits
    ctrl_word = 32'h1; step(0, 0, 0, 0); ctrl_word = '0;
    chk(samp_idx == 0 && !pkt_active, "R10 soft reset", samp_idx, 0);
    ctrl_word = 32'hFFFF_FFFE;
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk(samp_idx == 2 && pkt_active, "R10 other bits ignored", samp_idx, 2);
    ctrl_word = '0;
    step(1, 0, 0, 1);

    // R8 end freezes index and cancels pending start
    cfg_start_dly = 7'd20; cfg_corr_thresh = 16'd10;
    step(1, 1, 0, 0);
    repeat (3) step(1, 0, 0, 0);
    step(1, 0, 0, 1);
    nstart = 0;
    for (int s = 0; s < 30; s++) begin
      step(1, 0, 16'd50, 0);
      if (proc_start) nstart++;
    end
    chk(samp_idx == 3 && !pkt_active, "R8 frozen idx", samp_idx, 3);
    chk(nstart == 0, "R8 start cancelled", nstart, 0);

    // R1 hardware reset from mid-packet
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    chk(samp_idx == 0 && !pkt_active, "R1 reset mid-packet", samp_idx, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule